// File: doc/BRIEF.md
# Overcurrent and Thermal Fault Policy Controller

This block decides when a power switch may conduct. It watches digital comparator results from the analog side: current at the programmed limit, current above twice the limit, an excessive drop across the switch, and over-temperature together with a cooled indication. From these and a 2-bit policy code it runs a blanking window and an off-time timer. Based on the selected policy it turns the switch off and later back on, turns it off for good, or leaves it on. The analog loop that holds the current at the limit sits outside this block and is not part of it.

Three policies exist: latch-off, auto-retry, and continuous. In every policy, a severe overcurrent cuts the switch at once and restarts it after a short fixed off time. The blanking count is not cleared during that off time, so repeated severe events still end in the latch-off or retry action. Thermal recovery differs by policy. The combined fault output is a registered OR of six fault conditions. All timing is counted in clock ticks. The retry time is fixed at 30 blanking windows.

Top module: `ocp_fault_ctrl`

## Requirements
- R1: After reset, sw_en_o is 1 and fault_o is 0.
- R2: fault_o equals the OR of drop_hi_i, rev_trip_i, over_temp_i, iset_fault_i, uv_i and ov_i, sampled at the previous clock edge.
- R3: While the switch is on, the blanking count advances on each edge that samples at_limit_i or severe_i high. It clears on an on-state edge where both are low. Fewer than BLANK_TICKS consecutive counted edges never turn the switch off.
- R4: With mode_i = 01 (auto-retry), the edge that samples the BLANK_TICKS-th counted cycle turns sw_en_o off. The switch stays off for RETRY_TICKS edges, then turns on, and the cycle repeats while the overload persists.
- R5: RETRY_TICKS is always 30 times BLANK_TICKS.
- R6: With mode_i = 00 (latch-off), blanking expiry turns sw_en_o off. The switch stays off when every fault input returns low.
- R7: A one-cycle pulse on en_toggle_i or in_cycle_i while latched off turns sw_en_o on at the next edge. These pulses clear only the latched-off state.
- R8: With mode_i = 10 or 11 (continuous), at_limit_i held high for any time never turns sw_en_o off.
- R9: In any mode, severe_i sampled high while on turns sw_en_o off at that edge. The switch turns back on after RESTART_TICKS edges. The blanking count is held during this off time, so a severe overload that persists still reaches blanking expiry in modes 00 and 01.
- R10: Over-temperature while on turns sw_en_o off. In mode 01, the edge that samples cooled_i high starts a RETRY_TICKS off time, after which the switch turns on.
- R11: In modes 10 and 11, the edge that samples cooled_i high after an over-temperature trip starts a DEBOUNCE_TICKS off time, after which the switch turns on.
- R12: In mode 00, over-temperature latches the switch off. cooled_i does not release it; only R7 does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Fault policy code: 00 latch-off, 01 auto-retry, 1x continuous |
| at_limit_i | input | 1 | Current is at the programmed limit |
| severe_i | input | 1 | Current is above twice the limit |
| drop_hi_i | input | 1 | Drop across the switch is above its threshold |
| over_temp_i | input | 1 | Die temperature is above the shutdown level |
| cooled_i | input | 1 | Die has cooled below the recovery level |
| rev_trip_i | input | 1 | Reverse-current protection has tripped |
| iset_fault_i | input | 1 | Current-setting resistor is missing or shorted |
| uv_i | input | 1 | Input supply is below the undervoltage level |
| ov_i | input | 1 | Input supply is above the overvoltage level |
| en_toggle_i | input | 1 | One-cycle pulse: an enable was toggled |
| in_cycle_i | input | 1 | One-cycle pulse: the input supply was cycled |
| sw_en_o | output | 1 | Switch enable |
| fault_o | output | 1 | Combined fault flag |

## Verification
The properties assume that all inputs are synchronous to clk. They also assume that en_toggle_i and in_cycle_i are single-cycle pulses, and that mode_i changes only while the switch is conducting with no overload present. The stimulus changes mode_i only between scenarios, after sw_en_o has returned high. It raises cooled_i only after over_temp_i has been released, and it drives every input at the falling edge so that each rising edge sees settled values.

// File: rtl/ocp_fault_pkg.sv
package ocp_fault_pkg;

    typedef enum logic [2:0] {
        ST_ON,
        ST_SEVERE,
        ST_RETRY,
        ST_HOT,
        ST_DEB,
        ST_LATCH
    } ocp_state_e;

    localparam logic [1:0] MODE_LATCH = 2'b00;
    localparam logic [1:0] MODE_RETRY = 2'b01;

    localparam int RETRY_RATIO = 30;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/ocp_blank_timer.sv
module ocp_blank_timer #(
    parameter int LIMIT = 24,
    localparam int W = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc_i,
    input  logic clr_i,
    output logic expire_o
);

    typedef struct packed {
        logic [W-1:0] cnt;
    } blank_st_t;

    blank_st_t st_d, st_q;

    assign expire_o = inc_i && (st_q.cnt == W'(LIMIT - 1));

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.cnt = '0;
        end else if (inc_i) begin
            st_d.cnt = expire_o ? '0 : st_q.cnt + W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/ocp_delay_timer.sv
module ocp_delay_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_i,
    input  logic [W-1:0] limit_i,
    output logic         done_o
);

    typedef struct packed {
        logic [W-1:0] cnt;
    } dly_st_t;

    dly_st_t st_d, st_q;

    assign done_o = run_i && (st_q.cnt == limit_i - W'(1));

    always_comb begin
        st_d = st_q;
        if (!run_i || done_o) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/ocp_fault_flag.sv
module ocp_fault_flag #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] cond_i,
    output logic         fault_o
);

    typedef struct packed {
        logic flag;
    } flag_st_t;

    flag_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.flag = |cond_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fault_o = st_q.flag;

endmodule

// File: rtl/ocp_fault_ctrl.sv
module ocp_fault_ctrl
    import ocp_fault_pkg::*;
#(
    parameter int BLANK_TICKS    = 24,
    parameter int RESTART_TICKS  = 8,
    parameter int DEBOUNCE_TICKS = 12,
    localparam int RETRY_TICKS   = RETRY_RATIO * BLANK_TICKS,
    localparam int MAX_TICKS     = max3(RETRY_TICKS, RESTART_TICKS, DEBOUNCE_TICKS),
    localparam int TW            = $clog2(MAX_TICKS + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_i,
    input  logic       at_limit_i,
    input  logic       severe_i,
    input  logic       drop_hi_i,
    input  logic       over_temp_i,
    input  logic       cooled_i,
    input  logic       rev_trip_i,
    input  logic       iset_fault_i,
    input  logic       uv_i,
    input  logic       ov_i,
    input  logic       en_toggle_i,
    input  logic       in_cycle_i,
    output logic       sw_en_o,
    output logic       fault_o
);

    typedef struct packed {
        ocp_state_e state;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;

    ocp_state_e    cur_state;
    logic          is_latch_mode;
    logic          is_retry_mode;
    logic          blank_inc;
    logic          blank_clr;
    logic          blank_expire;
    logic          tmr_run;
    logic [TW-1:0] tmr_limit;
    logic          tmr_done;

    assign cur_state     = st_q.state;
    assign is_latch_mode = (mode_i == MODE_LATCH);
    assign is_retry_mode = (mode_i == MODE_RETRY);

    // blanking window counts overload cycles only while conducting, and
    // only for the policies that act on its expiry
    assign blank_inc = (cur_state == ST_ON) && (at_limit_i || severe_i) && !mode_i[1];
    // the severe restart interval keeps the count so repeated trips accumulate
    assign blank_clr = !blank_inc && (cur_state != ST_SEVERE);

    ocp_blank_timer #(
        .LIMIT (BLANK_TICKS)
    ) u_blank (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc_i    (blank_inc),
        .clr_i    (blank_clr),
        .expire_o (blank_expire)
    );

    always_comb begin
        case (cur_state)
            ST_SEVERE: tmr_limit = TW'(RESTART_TICKS);
            ST_RETRY:  tmr_limit = TW'(RETRY_TICKS);
            default:   tmr_limit = TW'(DEBOUNCE_TICKS);
        endcase
    end

    assign tmr_run = (cur_state == ST_SEVERE) || (cur_state == ST_RETRY) ||
                     (cur_state == ST_DEB);

    ocp_delay_timer #(
        .W (TW)
    ) u_delay (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (tmr_run),
        .limit_i (tmr_limit),
        .done_o  (tmr_done)
    );

    ocp_fault_flag #(
        .N (6)
    ) u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .cond_i  ({drop_hi_i, rev_trip_i, over_temp_i, iset_fault_i, uv_i, ov_i}),
        .fault_o (fault_o)
    );

    always_comb begin
        st_d = st_q;
        case (cur_state)
            ST_ON: begin
                if (over_temp_i) begin
                    st_d.state = is_latch_mode ? ST_LATCH : ST_HOT;
                end else if (blank_expire) begin
                    st_d.state = is_latch_mode ? ST_LATCH : ST_RETRY;
                end else if (severe_i) begin
                    st_d.state = ST_SEVERE;
                end
            end
            ST_SEVERE, ST_RETRY, ST_DEB: begin
                if (tmr_done) begin
                    st_d.state = ST_ON;
                end
            end
            ST_HOT: begin
                if (is_latch_mode) begin
                    st_d.state = ST_LATCH;
                end else if (cooled_i) begin
                    st_d.state = is_retry_mode ? ST_RETRY : ST_DEB;
                end
            end
            ST_LATCH: begin
                if (en_toggle_i || in_cycle_i) begin
                    st_d.state = ST_ON;
                end
            end
            default: st_d.state = ST_LATCH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.state <= ST_ON;
        end else begin
            st_q <= st_d;
        end
    end

    assign sw_en_o = (cur_state == ST_ON);

endmodule

// File: rtl/ocp_fault_ctrl_chk.sv
module ocp_fault_ctrl_chk
    import ocp_fault_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode_i,
    input logic       at_limit_i,
    input logic       severe_i,
    input logic       over_temp_i,
    input logic       en_toggle_i,
    input logic       in_cycle_i,
    input logic       ov_i,
    input logic       uv_i,
    input logic       sw_en_o,
    input logic       fault_o,
    input ocp_state_e cur_state,
    input logic       tmr_done
);

    a_r2_supply_fault_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (ov_i || uv_i) |=> fault_o);

    a_r4_retry_holds_off: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == ST_RETRY && !tmr_done) |=> !sw_en_o);

    a_r6_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == ST_LATCH && !en_toggle_i && !in_cycle_i) |=> !sw_en_o);

    a_r7_latch_release: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == ST_LATCH && (en_toggle_i || in_cycle_i)) |=> sw_en_o);

    a_r8_continuous_stays_on: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_en_o && mode_i[1] && at_limit_i && !severe_i && !over_temp_i) |=> sw_en_o);

    a_r9_severe_cuts: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_en_o && severe_i) |=> !sw_en_o);

    a_r10_hot_cuts: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_en_o && over_temp_i) |=> !sw_en_o);

    a_r12_hot_latches: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_en_o && over_temp_i && mode_i == MODE_LATCH) |=> (cur_state == ST_LATCH));

endmodule

bind ocp_fault_ctrl ocp_fault_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode_i),
    .at_limit_i  (at_limit_i),
    .severe_i    (severe_i),
    .over_temp_i (over_temp_i),
    .en_toggle_i (en_toggle_i),
    .in_cycle_i  (in_cycle_i),
    .ov_i        (ov_i),
    .uv_i        (uv_i),
    .sw_en_o     (sw_en_o),
    .fault_o     (fault_o),
    .cur_state   (cur_state),
    .tmr_done    (tmr_done)
);

// File: tb/ocp_fault_ctrl_tb.sv
`timescale 1ns/1ps
module ocp_fault_ctrl_tb;

    localparam int BLANK   = 4;
    localparam int RESTART = 3;
    localparam int DEB     = 5;
    localparam int RETRY   = 30 * BLANK;

    // {drop_hi, rev_trip, iset_fault, uv, ov, expected fault}
    localparam logic [5:0] VEC [8] = '{
        6'b00000_0, 6'b10000_1, 6'b01000_1, 6'b00100_1,
        6'b00010_1, 6'b00001_1, 6'b10101_1, 6'b00000_0
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'b10;
    logic at_limit = 0, severe = 0, drop_hi = 0, over_temp = 0, cooled = 0;
    logic rev_trip = 0, iset_fault = 0, uv = 0, ov = 0, en_toggle = 0, in_cycle = 0;
    logic sw_en, fault;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    ocp_fault_ctrl #(
        .BLANK_TICKS    (BLANK),
        .RESTART_TICKS  (RESTART),
        .DEBOUNCE_TICKS (DEB)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .mode_i (mode), .at_limit_i (at_limit),
        .severe_i (severe), .drop_hi_i (drop_hi), .over_temp_i (over_temp),
        .cooled_i (cooled), .rev_trip_i (rev_trip), .iset_fault_i (iset_fault),
        .uv_i (uv), .ov_i (ov), .en_toggle_i (en_toggle), .in_cycle_i (in_cycle),
        .sw_en_o (sw_en), .fault_o (fault)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        tick(2);
        chk("R1 sw_en in reset", sw_en, 1'b1);
        chk("R1 fault in reset", fault, 1'b0);
        rst_n = 1'b1;
        tick(1);
        chk("R1 sw_en after reset", sw_en, 1'b1);
        chk("R1 fault after reset", fault, 1'b0);

        // R2: combined flag table, continuous mode
        mode = 2'b10;
        for (int i = 0; i < 8; i++) begin
            {drop_hi, rev_trip, iset_fault, uv, ov} = VEC[i][5:1];
            tick(1);
            chk("R2 fault OR", fault, VEC[i][0]);
        end
        over_temp = 1; tick(1);
        chk("R2 fault from over-temp", fault, 1'b1);
        over_temp = 0; cooled = 1; tick(1); cooled = 0;
        tick(DEB + 1);
        chk("R2 recovered for next test", sw_en, 1'b1);

        // R3: short overloads do not trip
        mode = 2'b01;
        at_limit = 1; tick(BLANK - 1); at_limit = 0; tick(1);
        at_limit = 1; tick(BLANK - 1);
        chk("R3 no trip below blanking", sw_en, 1'b1);
        at_limit = 0; tick(2);

        // R4 / R5: auto-retry cycle
        at_limit = 1; tick(BLANK - 1);
        chk("R4 on before expiry", sw_en, 1'b1);
        tick(1);
        chk("R4 off at expiry", sw_en, 1'b0);
        tick(RETRY - 1);
        chk("R5 still off at 30x-1", sw_en, 1'b0);
        tick(1);
        chk("R5 on at 30x blanking", sw_en, 1'b1);
        tick(BLANK);
        chk("R4 repeats while overloaded", sw_en, 1'b0);
        at_limit = 0; tick(RETRY + 3);
        chk("R4 stays on after overload clears", sw_en, 1'b1);

        // R6 / R7: latch-off
        mode = 2'b00;
        at_limit = 1; tick(BLANK); at_limit = 0;
        chk("R6 off at expiry", sw_en, 1'b0);
        tick(200);
        chk("R6 stays latched", sw_en, 1'b0);
        en_toggle = 1; tick(1); en_toggle = 0;
        chk("R7 enable toggle releases", sw_en, 1'b1);
        at_limit = 1; tick(BLANK); at_limit = 0; tick(5);
        chk("R6 latched again", sw_en, 1'b0);
        in_cycle = 1; tick(1); in_cycle = 0;
        chk("R7 input cycle releases", sw_en, 1'b1);

        // R8: continuous, both codes
        mode = 2'b10; at_limit = 1; tick(3 * BLANK);
        chk("R8 mode 10 stays on", sw_en, 1'b1);
        mode = 2'b11; tick(RETRY);
        chk("R8 mode 11 stays on", sw_en, 1'b1);
        at_limit = 0; mode = 2'b10; tick(1);

        // R9: severe pulse restart
        severe = 1; tick(1); severe = 0;
        chk("R9 severe cuts at once", sw_en, 1'b0);
        tick(RESTART - 1);
        chk("R9 off during restart", sw_en, 1'b0);
        tick(1);
        chk("R9 on after restart", sw_en, 1'b1);
        mode = 2'b00;
        severe = 1; tick(1); severe = 0; tick(RESTART);
        chk("R9 single pulse no latch", sw_en, 1'b1);
        tick(2);
        severe = 1; tick(4 * (RESTART + 1)); severe = 0; tick(20);
        chk("R9 persistent severe latches", sw_en, 1'b0);
        in_cycle = 1; tick(1); in_cycle = 0;
        chk("R9 released", sw_en, 1'b1);

        // R10: thermal in auto-retry
        mode = 2'b01;
        over_temp = 1; tick(1);
        chk("R10 hot cuts", sw_en, 1'b0);
        tick(30);
        chk("R10 off until cooled", sw_en, 1'b0);
        over_temp = 0; cooled = 1; tick(1); cooled = 0;
        tick(RETRY - 1);
        chk("R10 off during retry", sw_en, 1'b0);
        tick(1);
        chk("R10 on after retry", sw_en, 1'b1);

        // R11: thermal in continuous
        mode = 2'b11;
        over_temp = 1; tick(1); over_temp = 0; tick(10);
        chk("R11 off until cooled", sw_en, 1'b0);
        cooled = 1; tick(1); cooled = 0;
        tick(DEB - 1);
        chk("R11 off during debounce", sw_en, 1'b0);
        tick(1);
        chk("R11 on after debounce", sw_en, 1'b1);

        // R12: thermal in latch-off
        mode = 2'b00;
        over_temp = 1; tick(1); over_temp = 0;
        cooled = 1; tick(1); cooled = 0; tick(RETRY + 10);
        chk("R12 cooling does not release", sw_en, 1'b0);
        en_toggle = 1; tick(1); en_toggle = 0;
        chk("R12 toggle releases", sw_en, 1'b1);

        done = 1;
        summary();
        $finish;
    end

endmodule